// File: doc/BRIEF.md
# Pin Function-Select Register Bank

This block stores the alternate-function choice for every pin of one 32-pin GPIO bank. The pins form four groups of eight, and pin p belongs to group p/8. Software reaches the storage through a single-beat register request/response channel. The block drives a 4-bit function code per pin to the pad multiplexers. Each group's layout is fixed at elaboration by a 3-bit mode code:

- 0: 2-bit fields
- 1: 3-bit fields
- 2: 4-bit fields
- 3: GPIO-only
- 4: unrouted

Writes carry their own bit mask. The upper half-word of the write data selects which bits of the lower half-word are replaced, so software never has to read a register before updating it. Register addresses are derived from the group modes. Group 0 starts at address 0. Each later group starts where the one before it ends. A 2-bit, GPIO-only or unrouted group takes 4 bytes of address space. A 3-bit or 4-bit group takes 8 bytes, split across two registers. GPIO-only and unrouted groups have no storage, so their 4 bytes are an address hole.

The request channel follows valid/ready rules. A request is accepted on any rising edge where `req_valid` and `req_ready` are both high. The block never applies back-pressure: `req_ready` is always high. The response has no ready: exactly one `rsp_valid` pulse follows each accepted request, and the requester must take it.

Top module: `pinmux_cfg_bank`

## Requirements
- R1: After reset every stored register is zero, every pin's function code is 0, and `req_ready` is high.
- R2: An accepted write replaces bit i (0..15) of the addressed register only when `req_wdata[16+i]` is 1. Every other stored bit, and every pin output, keeps its value.
- R3: In a 2-bit group, pin k of the group (k = p mod 8) takes its code from bits [2k+1:2k] of the group's only register, zero-extended to 4 bits.
- R4: In a 3-bit group, pins k=0..4 take bits [3k+2:3k] of the first register, and pins k=5..7 take bits [3(k-5)+2:3(k-5)] of the second register at +4. Each code is zero-extended to 4 bits.
- R5: In a 4-bit group, pins k=0..3 take bits [4k+3:4k] of the first register, and pins k=4..7 take bits [4(k-4)+3:4(k-4)] of the second register at +4.
- R6: Group g begins at the sum of the address steps of groups 0..g-1. The step is 8 for 3-bit and 4-bit groups and 4 for all others.
- R7: A GPIO-only group's pins always output code 0. An access to its address slot changes nothing and gets an error response with read data 0.
- R8: An unrouted group's pins always output code 0. An access to its address slot gets an error response with read data 0.
- R9: A read of a stored register returns the stored 16 bits in `rsp_rdata[15:0]` and zeros in `rsp_rdata[31:16]`, with `rsp_err` low.
- R10: An access to an address that maps to no stored register returns data 0 and raises `rsp_err` for that single response, and changes no state. Misaligned addresses and addresses past the last group are included.
- R11: `rsp_valid` is high in exactly the cycle after each accepted request and low otherwise. A written value appears on `pin_func` from the same clock edge that accepts the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the register |
| req_wdata | input | 32 | [31:16] bit-enable mask, [15:0] new bits |
| rsp_valid | output | 1 | Response pulse, one per accepted request |
| rsp_rdata | output | 32 | Read data, zero for writes and errors |
| rsp_err | output | 1 | Access hit no stored register |
| pin_func | output | 4*8*NUM_GROUPS | Function code of pin p in bits [4p+3:4p] |

## Verification
Every result in this block is due one clock edge after it is caused. A response appears in the cycle after its request is accepted. A written code shows on `pin_func` right after the accepting edge, because the pin decode reads the storage directly. The bench drives each request on a falling edge and samples both the response and the pin codes one nanosecond after the next rising edge. It then advances one more edge with the request withdrawn to confirm the response pulse has ended. A second instance with a different group layout covers unrouted slots and a shifted address map.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

  localparam int PINS_PER_GROUP = 8;
  localparam int HALF_W         = 16;
  localparam int BUS_W          = 32;
  localparam int CODE_W         = 4;
  localparam int MODE_W         = 3;

  typedef enum logic [MODE_W-1:0] {
    GM_W2   = 3'd0,
    GM_W3   = 3'd1,
    GM_W4   = 3'd2,
    GM_GPIO = 3'd3,
    GM_NONE = 3'd4
  } grp_mode_e;

  // Bytes of address space one group occupies
  function automatic int grp_step(input grp_mode_e m);
    return (m == GM_W3 || m == GM_W4) ? 8 : 4;
  endfunction

  // Number of stored registers a group owns
  function automatic int grp_regs(input grp_mode_e m);
    case (m)
      GM_W2:          return 1;
      GM_W3, GM_W4:   return 2;
      default:        return 0;
    endcase
  endfunction

  // Bit-enabled update: upper half of the bus word enables lower-half bits
  function automatic logic [HALF_W-1:0] masked_merge(input logic [HALF_W-1:0] old_val,
                                                     input logic [BUS_W-1:0]  wword);
    return (old_val & ~wword[BUS_W-1:HALF_W]) | (wword[HALF_W-1:0] & wword[BUS_W-1:HALF_W]);
  endfunction

endpackage

// File: rtl/pinmux_addr_dec.sv
module pinmux_addr_dec
  import pinmux_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int ADDR_W     = 8,
  parameter logic [MODE_W*NUM_GROUPS-1:0] GROUP_MODES = {3'd3, 3'd0, 3'd1, 3'd2}
) (
  input  logic [ADDR_W-1:0]     addr,
  output logic [NUM_GROUPS-1:0] hit_grp,
  output logic                  hit_hi
);

  function automatic int base_of(input int g);
    int acc;
    acc = 0;
    for (int i = 0; i < g; i++) begin
      acc += grp_step(grp_mode_e'(GROUP_MODES[MODE_W*i +: MODE_W]));
    end
    return acc;
  endfunction

  logic [NUM_GROUPS-1:0] match_lo;
  logic [NUM_GROUPS-1:0] match_hi;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam grp_mode_e MODE = grp_mode_e'(GROUP_MODES[MODE_W*g +: MODE_W]);
    localparam int        BASE = base_of(g);
    localparam int        NREG = grp_regs(MODE);

    if (NREG >= 1) begin : g_lo
      assign match_lo[g] = (addr == ADDR_W'(BASE));
    end else begin : g_lo_none
      assign match_lo[g] = 1'b0;
    end

    if (NREG == 2) begin : g_hi
      assign match_hi[g] = (addr == ADDR_W'(BASE + 4));
    end else begin : g_hi_none
      assign match_hi[g] = 1'b0;
    end
  end

  assign hit_grp = match_lo | match_hi;
  assign hit_hi  = |match_hi;

endmodule

// File: rtl/pinmux_group.sv
module pinmux_group
  import pinmux_pkg::*;
#(
  parameter grp_mode_e MODE = GM_W4,
  localparam int NREG = (MODE == GM_W2) ? 1 : 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NREG-1:0]                    we,
  input  logic [BUS_W-1:0]                   wword,
  output logic [NREG*HALF_W-1:0]             rdata,
  output logic [PINS_PER_GROUP*CODE_W-1:0]   codes
);

  logic [NREG-1:0][HALF_W-1:0] mem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (we[r]) mem_q[r] <= masked_merge(mem_q[r], wword);
      end
    end
  end

  assign rdata = mem_q;

  for (genvar k = 0; k < PINS_PER_GROUP; k++) begin : g_pin
    if (MODE == GM_W2) begin : g_w2
      assign codes[CODE_W*k +: CODE_W] = {2'b00, mem_q[0][2*k +: 2]};
    end else if (MODE == GM_W3) begin : g_w3
      if (k < 5) begin : g_lo
        assign codes[CODE_W*k +: CODE_W] = {1'b0, mem_q[0][3*k +: 3]};
      end else begin : g_hi
        assign codes[CODE_W*k +: CODE_W] = {1'b0, mem_q[NREG-1][3*(k-5) +: 3]};
      end
    end else begin : g_w4
      if (k < 4) begin : g_lo
        assign codes[CODE_W*k +: CODE_W] = mem_q[0][4*k +: 4];
      end else begin : g_hi
        assign codes[CODE_W*k +: CODE_W] = mem_q[NREG-1][4*(k-4) +: 4];
      end
    end
  end

endmodule

// File: rtl/pinmux_cfg_bank.sv
module pinmux_cfg_bank
  import pinmux_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int ADDR_W     = 8,
  parameter logic [MODE_W*NUM_GROUPS-1:0] GROUP_MODES = {3'd3, 3'd0, 3'd1, 3'd2},
  localparam int GRP_CODE_W = PINS_PER_GROUP * CODE_W,
  localparam int OUT_W      = NUM_GROUPS * GRP_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BUS_W-1:0]  req_wdata,
  output logic              rsp_valid,
  output logic [BUS_W-1:0]  rsp_rdata,
  output logic              rsp_err,
  output logic [OUT_W-1:0]  pin_func
);

  logic                              accept;
  logic [NUM_GROUPS-1:0]             hit_grp;
  logic                              hit_hi;
  logic                              hit_any;
  logic [NUM_GROUPS-1:0][HALF_W-1:0] grp_rd_lo;
  logic [NUM_GROUPS-1:0][HALF_W-1:0] grp_rd_hi;
  logic [HALF_W-1:0]                 rd_sel;

  assign req_ready = 1'b1;
  assign accept    = req_valid & req_ready;
  assign hit_any   = |hit_grp;

  pinmux_addr_dec #(
    .NUM_GROUPS  (NUM_GROUPS),
    .ADDR_W      (ADDR_W),
    .GROUP_MODES (GROUP_MODES)
  ) u_dec (
    .addr    (req_addr),
    .hit_grp (hit_grp),
    .hit_hi  (hit_hi)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam grp_mode_e MODE = grp_mode_e'(GROUP_MODES[MODE_W*g +: MODE_W]);
    localparam int        NREG = grp_regs(MODE);

    logic wr_lo;
    logic wr_hi;
    assign wr_lo = accept & req_write & hit_grp[g] & ~hit_hi;
    assign wr_hi = accept & req_write & hit_grp[g] &  hit_hi;

    if (NREG == 2) begin : g_two
      logic [2*HALF_W-1:0] rd;
      pinmux_group #(.MODE(MODE)) u_grp (
        .clk   (clk),
        .rst_n (rst_n),
        .we    ({wr_hi, wr_lo}),
        .wword (req_wdata),
        .rdata (rd),
        .codes (pin_func[GRP_CODE_W*g +: GRP_CODE_W])
      );
      assign grp_rd_lo[g] = rd[HALF_W-1:0];
      assign grp_rd_hi[g] = rd[2*HALF_W-1:HALF_W];
    end else if (NREG == 1) begin : g_one
      logic [HALF_W-1:0] rd;
      logic              unused_hi;
      pinmux_group #(.MODE(MODE)) u_grp (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_lo),
        .wword (req_wdata),
        .rdata (rd),
        .codes (pin_func[GRP_CODE_W*g +: GRP_CODE_W])
      );
      assign unused_hi    = wr_hi;
      assign grp_rd_lo[g] = rd;
      assign grp_rd_hi[g] = '0;
    end else begin : g_dead
      logic unused_wr;
      assign unused_wr    = wr_lo | wr_hi;
      assign grp_rd_lo[g] = '0;
      assign grp_rd_hi[g] = '0;
      assign pin_func[GRP_CODE_W*g +: GRP_CODE_W] = '0;
    end
  end

  always_comb begin
    rd_sel = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (hit_grp[g]) rd_sel = hit_hi ? grp_rd_hi[g] : grp_rd_lo[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= accept;
      rsp_err   <= accept & ~hit_any;
      rsp_rdata <= (accept & ~req_write & hit_any) ? {{(BUS_W-HALF_W){1'b0}}, rd_sel} : '0;
    end
  end

endmodule

// File: rtl/pinmux_cfg_sva.sv
module pinmux_cfg_sva
  import pinmux_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int ADDR_W     = 8,
  parameter logic [MODE_W*NUM_GROUPS-1:0] GROUP_MODES = {3'd3, 3'd0, 3'd1, 3'd2},
  localparam int GRP_CODE_W = PINS_PER_GROUP * CODE_W,
  localparam int OUT_W      = NUM_GROUPS * GRP_CODE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [BUS_W-1:0]  req_wdata,
  input logic              rsp_valid,
  input logic [BUS_W-1:0]  rsp_rdata,
  input logic              rsp_err,
  input logic [OUT_W-1:0]  pin_func
);

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) |=> rsp_valid); // R11
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n) !(req_valid && req_ready) |=> !rsp_valid); // R11
  AST_PINS_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !(req_valid && req_write) |=> $stable(pin_func)); // R2
  AST_ERR_KEEPS_PINS: assert property (@(posedge clk) disable iff (!rst_n) rsp_err |-> $stable(pin_func)); // R10
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n) rsp_err |-> (rsp_valid && rsp_rdata == '0)); // R10
  AST_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> rsp_rdata[BUS_W-1:HALF_W] == '0); // R9

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
    localparam grp_mode_e MODE = grp_mode_e'(GROUP_MODES[MODE_W*g +: MODE_W]);
    if (MODE == GM_GPIO) begin : g_gpio
      AST_GPIO_GROUP_ZERO: assert property (@(posedge clk) disable iff (!rst_n) pin_func[GRP_CODE_W*g +: GRP_CODE_W] == '0); // R7
    end else if (MODE == GM_NONE) begin : g_none
      AST_UNROUTED_GROUP_ZERO: assert property (@(posedge clk) disable iff (!rst_n) pin_func[GRP_CODE_W*g +: GRP_CODE_W] == '0); // R8
    end
  end

  logic unused_in;
  assign unused_in = ^{req_addr, req_wdata};

endmodule

bind pinmux_cfg_bank pinmux_cfg_sva #(
  .NUM_GROUPS  (NUM_GROUPS),
  .ADDR_W      (ADDR_W),
  .GROUP_MODES (GROUP_MODES)
) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .rsp_err   (rsp_err),
  .pin_func  (pin_func)
);

// File: tb/pinmux_cfg_bank_tb_top.sv
module pinmux_cfg_bank_tb_top;

  // Layout A: g0 4-bit @0x00/0x04, g1 3-bit @0x08/0x0C, g2 2-bit @0x10, g3 GPIO-only @0x14
  localparam logic [11:0] MODES_A = {3'd3, 3'd0, 3'd1, 3'd2};
  // Layout B: g0 GPIO-only @0x00, g1 unrouted @0x04, g2 2-bit @0x08, g3 4-bit @0x0C/0x10
  localparam logic [11:0] MODES_B = {3'd2, 3'd0, 3'd4, 3'd3};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        a_valid = 0, a_write = 0, a_ready, a_rvalid, a_err;
  logic [7:0]  a_addr = '0;
  logic [31:0] a_wdata = '0, a_rdata;
  logic [127:0] a_pins;

  logic        b_valid = 0, b_write = 0, b_ready, b_rvalid, b_err;
  logic [7:0]  b_addr = '0;
  logic [31:0] b_wdata = '0, b_rdata;
  logic [127:0] b_pins;

  pinmux_cfg_bank #(.NUM_GROUPS(4), .ADDR_W(8), .GROUP_MODES(MODES_A)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(a_valid), .req_ready(a_ready),
    .req_write(a_write), .req_addr(a_addr), .req_wdata(a_wdata),
    .rsp_valid(a_rvalid), .rsp_rdata(a_rdata), .rsp_err(a_err), .pin_func(a_pins));

  pinmux_cfg_bank #(.NUM_GROUPS(4), .ADDR_W(8), .GROUP_MODES(MODES_B)) dut_b_i (
    .clk(clk), .rst_n(rst_n), .req_valid(b_valid), .req_ready(b_ready),
    .req_write(b_write), .req_addr(b_addr), .req_wdata(b_wdata),
    .rsp_valid(b_rvalid), .rsp_rdata(b_rdata), .rsp_err(b_err), .pin_func(b_pins));

  int n_checks = 0;
  int n_errs   = 0;

  logic [31:0] got_data;
  logic        got_err;
  logic        got_vld;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] pin(input bit on_b, input int p);
    return on_b ? b_pins[4*p +: 4] : a_pins[4*p +: 4];
  endfunction

  // One request; response sampled 1 ns after the accepting edge
  task automatic xfer(input bit on_b, input bit wr, input logic [7:0] addr, input logic [31:0] data);
    @(negedge clk);
    if (on_b) begin b_valid = 1; b_write = wr; b_addr = addr; b_wdata = data; end
    else      begin a_valid = 1; a_write = wr; a_addr = addr; a_wdata = data; end
    @(posedge clk);
    #1;
    got_vld  = on_b ? b_rvalid : a_rvalid;
    got_err  = on_b ? b_err    : a_err;
    got_data = on_b ? b_rdata  : a_rdata;
    @(negedge clk);
    a_valid = 0; b_valid = 0;
  endtask

  task automatic chk_pins(input bit on_b, input string req, input int first, input logic [3:0] exp [8]);
    for (int k = 0; k < 8; k++) chk(req, $sformatf("pin%0d", first + k), 32'(pin(on_b, first + k)), 32'(exp[k]));
  endtask

  task automatic t_reset();
    chk("R1", "all pins A", a_pins[31:0] | a_pins[63:32] | a_pins[95:64] | a_pins[127:96], 0);
    chk("R1", "all pins B", b_pins[31:0] | b_pins[63:32] | b_pins[95:64] | b_pins[127:96], 0);
    chk("R1", "ready", 32'(a_ready), 1);
    xfer(0, 0, 8'h00, 0);
    chk("R1", "read 0x00", got_data, 0);
    chk("R9", "err on good read", 32'(got_err), 0);
  endtask

  task automatic t_two_bit();
    xfer(0, 1, 8'h10, 32'hFFFF_1BE4);
    chk("R11", "rsp_valid", 32'(got_vld), 1);
    chk_pins(0, "R3", 16, '{4'd0, 4'd1, 4'd2, 4'd3, 4'd3, 4'd2, 4'd1, 4'd0});
    @(posedge clk); #1;
    chk("R11", "rsp pulse ends", 32'(a_rvalid), 0);
  endtask

  task automatic t_mask();
    xfer(0, 1, 8'h10, 32'h00F0_0000);
    chk_pins(0, "R2", 16, '{4'd0, 4'd1, 4'd0, 4'd0, 4'd3, 4'd2, 4'd1, 4'd0});
    xfer(0, 1, 8'h10, 32'h0003_FFFE);
    chk("R2", "pin16 partial", 32'(pin(0, 16)), 2);
    xfer(0, 1, 8'h10, 32'h0000_FFFF);
    xfer(0, 0, 8'h10, 0);
    chk("R2", "readback after masks", got_data, 32'h0000_1B06);
  endtask

  task automatic t_three_bit();
    xfer(0, 1, 8'h08, 32'hFFFF_58D1);
    xfer(0, 1, 8'h0C, 32'hFFFF_00FE);
    chk_pins(0, "R4", 8, '{4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd3});
  endtask

  task automatic t_four_bit();
    xfer(0, 1, 8'h00, 32'hFFFF_A5C3);
    xfer(0, 1, 8'h04, 32'hFFFF_0F71);
    chk_pins(0, "R5", 0, '{4'd3, 4'hC, 4'd5, 4'hA, 4'd1, 4'd7, 4'hF, 4'd0});
  endtask

  task automatic t_readback();
    xfer(0, 0, 8'h08, 0);
    chk("R9", "read 0x08", got_data, 32'h0000_58D1);
    chk("R9", "err", 32'(got_err), 0);
  endtask

  task automatic t_gpio();
    xfer(0, 1, 8'h14, 32'hFFFF_FFFF);
    chk("R7", "write err", 32'(got_err), 1);
    chk_pins(0, "R7", 24, '{4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0});
    xfer(0, 0, 8'h14, 0);
    chk("R7", "read data", got_data, 0);
    xfer(1, 1, 8'h00, 32'hFFFF_FFFF);
    chk("R7", "B gpio err", 32'(got_err), 1);
    chk_pins(1, "R7", 0, '{4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0});
  endtask

  task automatic t_unmapped();
    xfer(0, 1, 8'h18, 32'hFFFF_FFFF);
    chk("R10", "past end err", 32'(got_err), 1);
    xfer(0, 1, 8'h02, 32'hFFFF_FFFF);
    chk("R10", "misaligned err", 32'(got_err), 1);
    xfer(0, 0, 8'hFC, 0);
    chk("R10", "unmapped read data", got_data, 0);
    chk("R10", "unmapped read err", 32'(got_err), 1);
    xfer(0, 0, 8'h00, 0);
    chk("R10", "state kept", got_data, 32'h0000_A5C3);
    chk("R10", "err one cycle", 32'(got_err), 0);
    chk("R10", "pin1 kept", 32'(pin(0, 1)), 32'hC);
  endtask

  task automatic t_layout_b();
    xfer(1, 1, 8'h04, 32'hFFFF_FFFF);
    chk("R8", "unrouted err", 32'(got_err), 1);
    chk("R8", "unrouted read data", got_data, 0);
    chk_pins(1, "R8", 8, '{4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0});
    xfer(1, 1, 8'h08, 32'hFFFF_FFFF);
    chk("R6", "B g2 err", 32'(got_err), 0);
    chk_pins(1, "R6", 16, '{4'd3, 4'd3, 4'd3, 4'd3, 4'd3, 4'd3, 4'd3, 4'd3});
    xfer(1, 1, 8'h0C, 32'hFFFF_4321);
    xfer(1, 1, 8'h10, 32'hFFFF_0098);
    chk_pins(1, "R6", 24, '{4'd1, 4'd2, 4'd3, 4'd4, 4'd8, 4'd9, 4'd0, 4'd0});
    xfer(1, 0, 8'h10, 0);
    chk("R6", "B read 0x10", got_data, 32'h0000_0098);
    xfer(1, 0, 8'h14, 0);
    chk("R6", "B end err", 32'(got_err), 1);
    chk("R6", "A untouched by B", 32'(pin(0, 24)), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_errs++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_two_bit();
    t_mask();
    t_three_bit();
    t_four_bit();
    t_readback();
    t_gpio();
    t_unmapped();
    t_layout_b();
    repeat (2) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

endmodule